// File: doc/BRIEF.md
# PLL Digital Lock Detector with Hysteresis

This block watches the reference and feedback signals that feed a phase detector and reports whether the loop is in lock. Both signals are sampled in a fast clock domain. A rising edge on either input opens a measurement, and the block counts fast-clock cycles until the rising edge on the other input arrives. A short separation sets the lock flag. A long separation, or a missing partner edge, clears it. Separations between the two limits leave the flag unchanged. The gap between the set limit and the clear limit gives the flag hysteresis, so it does not toggle when the loop sits close to one limit.

Two pairs of limits are built in, and a select input chooses between them. The default pair is 19/30 cycles, which is 9.5/15 ns at a 0.5 ns tick. The alternate pair is 7/14 cycles, which is 3.5/7 ns. A disable input turns the detector off. A polarity input makes the output active low. If both inputs go quiet, the flag keeps its last value. This is expected behaviour and the block does not flag it.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset the detector is unlocked, and `lock_o` equals `pol_low_i` (its inactive level).
- R2: In the unlocked state, a partner edge that arrives d cycles after the leading edge, with 1 <= d <= LOCK_W (19 when `win_sel_i`=0), sets lock. Either input may lead. `lock_o` changes right after the clock edge that samples the partner's rising edge.
- R3: A separation d with LOCK_W < d < UNLOCK_W (20..29 for select 0) leaves the state unchanged. A locked detector stays locked and an unlocked detector stays unlocked.
- R4: A separation d >= UNLOCK_W (30 for select 0) clears lock right after the clock edge that samples the partner edge.
- R5: If no partner edge arrives, lock clears right after the clock edge that falls UNLOCK_W cycles after the edge that samples the leading edge. One cycle earlier, lock is still held.
- R6: Rising edges on both inputs in the same cycle count as a separation of zero and set lock.
- R7: With `win_sel_i`=1 the limits are 7 and 14 cycles. A separation of 7 sets lock and 8 does not. A separation of 13 keeps lock and 14 clears it.
- R8: While `disable_i`=1, `lock_o` is at its inactive level in the same cycle. The lock state is cleared, and any open measurement is dropped, so a later partner edge starts a new measurement.
- R9: `pol_low_i`=1 inverts `lock_o`, giving 0 when locked and 1 when unlocked.
- R10: A second rising edge on the leading input during an open measurement is ignored. The separation is still counted from the first edge.
- R11: With no edges on either input, a locked detector stays locked indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_i | input | 1 | Reference signal at the phase detector, synchronous to clk |
| fb_i | input | 1 | Feedback (divided) signal at the phase detector, synchronous to clk |
| win_sel_i | input | 1 | Limit pair select: 0 gives 19/30 cycles, 1 gives 7/14 cycles |
| disable_i | input | 1 | 1 turns the detector off |
| pol_low_i | input | 1 | 1 makes `lock_o` active low |
| lock_o | output | 1 | Lock indicator |

## Verification
A rising input is seen at the next clock edge. The separation d counts from the edge that samples the leading rise to the edge that samples the partner rise. The lock register updates at that same edge, so `lock_o` is due half a cycle later. The bench drives every input at a falling edge and samples at the following falling edge. The partner is raised d falling edges after the leader, and `lock_o` is read at the very next falling edge.

For a timeout, the flag is checked at the UNLOCK_W-th falling edge, where it must still be held, and at the one after, where it must be clear. Disable and polarity act on the output without a register in between, so those checks read `lock_o` one time step after the input is driven.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  typedef enum logic [1:0] {
    LEAD_NONE = 2'd0,
    LEAD_REF  = 2'd1,
    LEAD_FB   = 2'd2
  } lead_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lkd_rst_sync.sv
module lkd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/lkd_edge.sv
module lkd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/lkd_pair_timer.sv
module lkd_pair_timer
  import lkd_pkg::*;
#(
  parameter int LOCK_W0   = 19,
  parameter int UNLOCK_W0 = 30,
  parameter int LOCK_W1   = 7,
  parameter int UNLOCK_W1 = 14,
  parameter int CW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          sel_i,
  input  logic          ref_ev_i,
  input  logic          fb_ev_i,
  output logic          close_o,
  output logic          far_o,
  output logic [CW-1:0] cnt_o
);
  lead_e         lead_q, lead_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lock_lim, unl_lim;
  logic          partner;
  logic          upd_en;

  assign lock_lim = sel_i ? CW'(LOCK_W1)   : CW'(LOCK_W0);
  assign unl_lim  = sel_i ? CW'(UNLOCK_W1) : CW'(UNLOCK_W0);
  assign partner  = (lead_q == LEAD_REF) ? fb_ev_i : ref_ev_i;

  always_comb begin
    lead_d  = lead_q;
    cnt_d   = cnt_q;
    close_o = 1'b0;
    far_o   = 1'b0;
    if (clr_i) begin
      lead_d = LEAD_NONE;
      cnt_d  = '0;
    end else begin
      case (lead_q)
        LEAD_NONE: begin
          if (ref_ev_i && fb_ev_i) begin
            close_o = 1'b1;
          end else if (ref_ev_i) begin
            lead_d = LEAD_REF;
            cnt_d  = CW'(1);
          end else if (fb_ev_i) begin
            lead_d = LEAD_FB;
            cnt_d  = CW'(1);
          end
        end
        LEAD_REF, LEAD_FB: begin
          if (partner || (cnt_q >= unl_lim)) begin
            close_o = partner && (cnt_q <= lock_lim);
            far_o   = (cnt_q >= unl_lim);
            lead_d  = LEAD_NONE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: begin
          lead_d = LEAD_NONE;
          cnt_d  = '0;
        end
      endcase
    end
  end

  assign upd_en = clr_i || (lead_q != LEAD_NONE) || ref_ev_i || fb_ev_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q <= LEAD_NONE;
      cnt_q  <= '0;
    end else if (upd_en) begin
      lead_q <= lead_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lkd_hyst.sv
module lkd_hyst (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic close_i,
  input  logic far_i,
  input  logic pol_low_i,
  output logic locked_o,
  output logic lock_o
);
  logic lock_q, lock_d, lock_en;

  always_comb begin
    lock_d = lock_q;
    if (clr_i)        lock_d = 1'b0;
    else if (close_i) lock_d = 1'b1;
    else if (far_i)   lock_d = 1'b0;
  end

  assign lock_en = clr_i | close_i | far_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_d;
  end

  assign locked_o = lock_q;
  assign lock_o   = (lock_q & ~clr_i) ^ pol_low_i;
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import lkd_pkg::*;
#(
  parameter int LOCK_W0   = 19,
  parameter int UNLOCK_W0 = 30,
  parameter int LOCK_W1   = 7,
  parameter int UNLOCK_W1 = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  input  logic fb_i,
  input  logic win_sel_i,
  input  logic disable_i,
  input  logic pol_low_i,
  output logic lock_o
);
  localparam int UMAX = max2(UNLOCK_W0, UNLOCK_W1);
  localparam int CW   = $clog2(UMAX + 1);
  localparam int NIN  = 2;

  logic           rst_int_n;
  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] rise_ev;
  logic           close_ev, far_ev;
  logic [CW-1:0]  cnt;
  logic           lock_q;

  lkd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign raw_in = {fb_i, ref_i};

  for (genvar g = 0; g < NIN; g++) begin : g_edge
    lkd_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .sig_i  (raw_in[g]),
      .rise_o (rise_ev[g])
    );
  end

  lkd_pair_timer #(
    .LOCK_W0   (LOCK_W0),
    .UNLOCK_W0 (UNLOCK_W0),
    .LOCK_W1   (LOCK_W1),
    .UNLOCK_W1 (UNLOCK_W1),
    .CW        (CW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr_i    (disable_i),
    .sel_i    (win_sel_i),
    .ref_ev_i (rise_ev[0]),
    .fb_ev_i  (rise_ev[1]),
    .close_o  (close_ev),
    .far_o    (far_ev),
    .cnt_o    (cnt)
  );

  lkd_hyst u_hyst (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (disable_i),
    .close_i   (close_ev),
    .far_i     (far_ev),
    .pol_low_i (pol_low_i),
    .locked_o  (lock_q),
    .lock_o    (lock_o)
  );
endmodule

// File: rtl/lkd_checker.sv
module lkd_checker #(
  parameter int CW   = 5,
  parameter int UMAX = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          disable_i,
  input logic          pol_low_i,
  input logic          lock_o,
  input logic          lock_q,
  input logic          close_ev,
  input logic          far_ev,
  input logic [CW-1:0] cnt
);
  // R2: lock only rises after a close pair
  p_set_needs_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(close_ev));

  // R4: lock only falls after a far pair or a disable
  p_clear_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> ($past(far_ev) || $past(disable_i)));

  // R3: one pair cannot be both close and far
  p_events_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(close_ev && far_ev));

  // R5: the separation counter never passes the largest clear limit
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(UMAX));

  // R8: disable drives the inactive level and clears the state
  p_disable_inactive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |-> (lock_o == pol_low_i));
  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> !lock_q);
endmodule

bind pll_lock_detect lkd_checker #(.CW(CW), .UMAX(UMAX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .disable_i (disable_i),
  .pol_low_i (pol_low_i),
  .lock_o    (lock_o),
  .lock_q    (lock_q),
  .close_ev  (close_ev),
  .far_ev    (far_ev),
  .cnt       (cnt)
);

// File: tb/tb_pll_lock_detect.sv
`timescale 1ns/1ps
module tb_pll_lock_detect;
  logic clk = 1'b0;
  logic rst_n, ref_i, fb_i, win_sel_i, disable_i, pol_low_i;
  logic lock_o;
  int   n_checks = 0;
  int   n_fail   = 0;

  always #2.5 clk = ~clk;

  pll_lock_detect dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_i     (ref_i),
    .fb_i      (fb_i),
    .win_sel_i (win_sel_i),
    .disable_i (disable_i),
    .pol_low_i (pol_low_i),
    .lock_o    (lock_o)
  );

  task automatic check(input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: lock_o=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // lead: 0 = ref first, 1 = fb first; d = separation in cycles (0 = same cycle)
  task automatic pair(input int lead, input int d);
    @(negedge clk);
    if (d == 0) begin
      ref_i = 1'b1; fb_i = 1'b1;
    end else begin
      if (lead == 0) ref_i = 1'b1; else fb_i = 1'b1;
      repeat (d) @(negedge clk);
      if (lead == 0) fb_i = 1'b1; else ref_i = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic settle();
    ref_i = 1'b0; fb_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic go_locked();
    pair(0, 5); settle();
  endtask

  task automatic go_unlocked();
    pair(0, 30); settle();
  endtask

  task automatic t_reset();
    check("R1 reset", lock_o, 1'b0);
  endtask

  task automatic t_set_limit();
    pair(0, 20); check("R3 d=20 from unlocked", lock_o, 1'b0); settle();
    pair(0, 19); check("R2 d=19 ref first", lock_o, 1'b1); settle();
    go_unlocked();
    pair(1, 12); check("R2 d=12 fb first", lock_o, 1'b1); settle();
  endtask

  task automatic t_hold_and_clear();
    pair(0, 29); check("R3 d=29 keeps lock", lock_o, 1'b1); settle();
    pair(1, 25); check("R3 d=25 fb first keeps lock", lock_o, 1'b1); settle();
    pair(0, 30); check("R4 d=30 clears", lock_o, 1'b0); settle();
  endtask

  task automatic t_simultaneous();
    pair(0, 0); check("R6 same cycle", lock_o, 1'b1); settle();
  endtask

  task automatic t_timeout();
    go_locked();
    @(negedge clk); ref_i = 1'b1;
    repeat (30) @(negedge clk);
    check("R5 held at cycle 30", lock_o, 1'b1);
    @(negedge clk);
    check("R5 cleared after cycle 30", lock_o, 1'b0);
    settle();
  endtask

  task automatic t_alt_windows();
    win_sel_i = 1'b1;
    pair(0, 8);  check("R7 d=8 no lock", lock_o, 1'b0); settle();
    pair(0, 7);  check("R7 d=7 locks", lock_o, 1'b1); settle();
    pair(1, 13); check("R7 d=13 keeps", lock_o, 1'b1); settle();
    pair(0, 14); check("R7 d=14 clears", lock_o, 1'b0); settle();
    win_sel_i = 1'b0;
  endtask

  task automatic t_disable();
    go_locked();
    @(negedge clk); disable_i = 1'b1; #1;
    check("R8 inactive while disabled", lock_o, 1'b0);
    @(negedge clk); disable_i = 1'b0; #1;
    check("R8 state cleared", lock_o, 1'b0);
    @(negedge clk); disable_i = 1'b1; ref_i = 1'b1;
    @(negedge clk); disable_i = 1'b0;
    repeat (2) @(negedge clk); fb_i = 1'b1;
    @(negedge clk);
    check("R8 open pair dropped", lock_o, 1'b0);
    ref_i = 1'b0; fb_i = 1'b0;
    repeat (35) @(negedge clk);
    check("R8 still unlocked", lock_o, 1'b0);
  endtask

  task automatic t_polarity();
    @(negedge clk); pol_low_i = 1'b1; #1;
    check("R9 unlocked active low", lock_o, 1'b1);
    pair(0, 3); check("R9 locked active low", lock_o, 1'b0); settle();
    pol_low_i = 1'b0; #1;
    check("R9 back to active high", lock_o, 1'b1);
    go_unlocked();
  endtask

  task automatic t_repeat_lead();
    @(negedge clk); ref_i = 1'b1;
    repeat (3) @(negedge clk); ref_i = 1'b0;
    repeat (7) @(negedge clk); ref_i = 1'b1;
    repeat (15) @(negedge clk); fb_i = 1'b1;
    @(negedge clk);
    check("R10 second lead edge ignored", lock_o, 1'b0);
    settle();
  endtask

  task automatic t_quiet();
    go_locked();
    repeat (200) @(negedge clk);
    check("R11 lock held with no edges", lock_o, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; ref_i = 1'b0; fb_i = 1'b0;
    win_sel_i = 1'b0; disable_i = 1'b0; pol_low_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set_limit();
    t_hold_and_clear();
    t_simultaneous();
    t_timeout();
    t_alt_windows();
    t_disable();
    t_polarity();
    t_repeat_lead();
    t_quiet();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule